// File: doc/BRIEF.md
# CPU Frame Injection Framer

This block turns a frame that a CPU hands over as a stream of 32-bit words with byte enables into the series of word writes that a switch injection queue expects. Each write either carries data or is a control write with sideband fields for start of frame, end of frame, valid bytes in the last word and inter-frame gap. A frame opens with a start control write. After that come a fixed-length internal header taken from a parallel input, the payload words, and zero words that lift a short frame to the 60-byte minimum. The frame then closes with an end control write and one trailing zero word.

When a frame is offered, the block first looks at the queue-ready status. If the queue is not ready, it reports a one-cycle busy pulse and drains the frame without writing anything. After a frame has been written, a set watermark status starts a fixed backpressure interval. During that interval the input stream is held off and no new frame can start.

Top module: `inj_framer`

## Requirements
- R1: After reset the block makes no write, holds `s_ready` low and keeps `busy` and `stop` low.
- R2: If `q_ready` is low when a frame is offered, `busy` is high for exactly one cycle. The whole frame is consumed, and no write is made for it.
- R3: The first write of an accepted frame is a control write (`wr_ctrl`=1) with `wr_sof`=1, `wr_eof`=0, `wr_gap`=1, `wr_vld`=0 and zero data.
- R4: Next come `HDR_WORDS` data writes. Header word i is `hdr_in[32*i +: 32]`, taken as `hdr_in` stood on the cycle the frame was accepted. Later changes to `hdr_in` have no effect on that frame.
- R5: Next come the payload words, ceil(length/4) data writes, in order and unchanged. Every word except the last has `s_keep`=4'hF. The last word has its valid bytes in the low lanes, and length is the sum of set `s_keep` bits over the frame.
- R6: If fewer than 15 payload words were written, zero data writes follow until 15 data words have been written after the header.
- R7: Next is a control write with `wr_eof`=1, `wr_sof`=0 and `wr_gap`=1. Its `wr_vld` is 0 if length < 60, and otherwise length mod 4.
- R8: Exactly one zero data write follows the end control write. Writes of a frame are made in consecutive cycles except while the payload waits on `s_valid`.
- R9: If `q_wmark` is high in the cycle of the trailing zero write, `stop` rises on the next cycle and stays high for exactly `STOP_CYCLES` cycles (default 6250, which is 50 us at 125 MHz).
- R10: While `stop` is high, `s_ready` is low, no write is made and no frame starts, even with `s_valid` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted |
| s_data | input | 32 | Stream word |
| s_keep | input | 4 | Byte enables of the stream word |
| s_last | input | 1 | Last word of the frame |
| hdr_in | input | 32*HDR_WORDS | Internal header, word 0 in the low bits |
| q_ready | input | 1 | Injection queue ready status |
| q_wmark | input | 1 | Injection queue watermark reached status |
| busy | output | 1 | One-cycle pulse: frame refused |
| stop | output | 1 | Backpressure interval active |
| wr_valid | output | 1 | A queue write is made this cycle |
| wr_ctrl | output | 1 | 1: control write, 0: data write |
| wr_sof | output | 1 | Control: start of frame |
| wr_eof | output | 1 | Control: end of frame |
| wr_vld | output | 2 | Control: valid bytes code |
| wr_gap | output | 2 | Control: gap size |
| wr_data | output | 32 | Write data |

## Verification
A sequencer that goes wrong shows up at the queue write port in the same frame. It appears as a write in the wrong position, a header word taken from the wrong index, a missing or extra pad word, or a missing trailing word. Comparing the full write list of each frame against a model therefore catches it by the end of that frame. A wrong byte count shows up only in the valid-byte code of the end control write, so the lengths tested lie on both sides of 60 and cover every residue mod 4. A timer fault shows up as a backpressure interval of the wrong length, which is measured cycle by cycle.

// File: rtl/inj_pkg.sv
package inj_pkg;

    localparam int WORD_W          = 32;
    localparam int BYTE_CNT_W      = 16;
    localparam int MIN_FRAME_BYTES = 60;
    localparam int MIN_FRAME_WORDS = MIN_FRAME_BYTES / 4;
    localparam logic [1:0] GAP_DEFAULT = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF,
        ST_HDR,
        ST_PAY,
        ST_PAD,
        ST_EOF,
        ST_TAIL,
        ST_DROP
    } fr_state_e;

    typedef struct packed {
        logic              ctrl;
        logic              sof;
        logic              eof;
        logic [1:0]        vld;
        logic [1:0]        gap;
        logic [WORD_W-1:0] data;
    } qwrite_t;

    function automatic logic [2:0] lane_count(input logic [3:0] keep);
        return {2'b00, keep[0]} + {2'b00, keep[1]} + {2'b00, keep[2]} + {2'b00, keep[3]};
    endfunction

    function automatic logic [1:0] end_valid_code(input logic [BYTE_CNT_W-1:0] nbytes);
        return (nbytes < BYTE_CNT_W'(MIN_FRAME_BYTES)) ? 2'd0 : nbytes[1:0];
    endfunction

endpackage

// File: rtl/inj_hdr_bank.sv
module inj_hdr_bank
    import inj_pkg::*;
#(
    parameter int HDR_WORDS = 9
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        capture_i,
    input  logic                        advance_i,
    input  logic [HDR_WORDS*WORD_W-1:0] hdr_i,
    output logic [WORD_W-1:0]           word_o,
    output logic                        last_o
);
    localparam int IDX_W = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;

    logic [HDR_WORDS*WORD_W-1:0] bank_q;
    logic [IDX_W-1:0]            idx_q;
    logic [WORD_W-1:0]           words [HDR_WORDS];

    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_view
        assign words[g] = bank_q[g*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
            idx_q  <= '0;
        end else if (capture_i) begin
            bank_q <= hdr_i;
            idx_q  <= '0;
        end else if (advance_i) begin
            idx_q  <= last_o ? '0 : idx_q + 1'b1;
        end
    end

    assign word_o = words[idx_q];
    assign last_o = (idx_q == IDX_W'(HDR_WORDS - 1));

    // Index never leaves the header range (R4)
    p_idx_range_r4: assert property (@(posedge clk) disable iff (rst)
        advance_i |=> (idx_q < IDX_W'(HDR_WORDS)));

endmodule

// File: rtl/inj_len_track.sv
module inj_len_track
    import inj_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear_i,
    input  logic                  pay_fire_i,
    input  logic [3:0]            pay_keep_i,
    input  logic                  pad_fire_i,
    output logic [BYTE_CNT_W-1:0] bytes_o,
    output logic                  need_pad_o
);
    logic [BYTE_CNT_W-1:0] words_q;
    logic [BYTE_CNT_W-1:0] bytes_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            words_q <= '0;
            bytes_q <= '0;
        end else begin
            if (pay_fire_i || pad_fire_i) words_q <= words_q + 1'b1;
            if (pay_fire_i) bytes_q <= bytes_q + BYTE_CNT_W'(lane_count(pay_keep_i));
        end
    end

    assign bytes_o    = bytes_q;
    assign need_pad_o = (words_q + 1'b1) < BYTE_CNT_W'(MIN_FRAME_WORDS);

    // Padding never runs past the minimum word count (R6)
    p_pad_bound_r6: assert property (@(posedge clk) disable iff (rst)
        pad_fire_i |-> (words_q < BYTE_CNT_W'(MIN_FRAME_WORDS)));

    // A pad word and a payload word never share a cycle (R6)
    p_pad_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(pad_fire_i && pay_fire_i));

endmodule

// File: rtl/inj_stop_timer.sv
module inj_stop_timer #(
    parameter int STOP_CYCLES = 6250
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic stop_o
);
    localparam int CNT_W = $clog2(STOP_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CNT_W'(STOP_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign stop_o = (cnt_q != '0);

    // Stop only starts right after a load request (R9)
    p_stop_start_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_o) |-> $past(load_i));

endmodule

// File: rtl/inj_framer.sv
module inj_framer
    import inj_pkg::*;
#(
    parameter int HDR_WORDS   = 9,
    parameter int STOP_CYCLES = 6250
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        s_valid,
    output logic                        s_ready,
    input  logic [31:0]                 s_data,
    input  logic [3:0]                  s_keep,
    input  logic                        s_last,
    input  logic [32*HDR_WORDS-1:0]     hdr_in,
    input  logic                        q_ready,
    input  logic                        q_wmark,
    output logic                        busy,
    output logic                        stop,
    output logic                        wr_valid,
    output logic                        wr_ctrl,
    output logic                        wr_sof,
    output logic                        wr_eof,
    output logic [1:0]                  wr_vld,
    output logic [1:0]                  wr_gap,
    output logic [31:0]                 wr_data
);
    fr_state_e state_q, state_n;
    qwrite_t   wr;
    logic      wr_v;

    logic                  hdr_cap, hdr_adv, hdr_last;
    logic [WORD_W-1:0]     hdr_word;
    logic                  len_clr, pay_fire, pad_fire, need_pad;
    logic [BYTE_CNT_W-1:0] byte_cnt;
    logic                  stop_load;

    inj_hdr_bank #(.HDR_WORDS(HDR_WORDS)) u_hdr (
        .clk       (clk),
        .rst       (rst),
        .capture_i (hdr_cap),
        .advance_i (hdr_adv),
        .hdr_i     (hdr_in),
        .word_o    (hdr_word),
        .last_o    (hdr_last)
    );

    inj_len_track u_len (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (len_clr),
        .pay_fire_i (pay_fire),
        .pay_keep_i (s_keep),
        .pad_fire_i (pad_fire),
        .bytes_o    (byte_cnt),
        .need_pad_o (need_pad)
    );

    inj_stop_timer #(.STOP_CYCLES(STOP_CYCLES)) u_stop (
        .clk    (clk),
        .rst    (rst),
        .load_i (stop_load),
        .stop_o (stop)
    );

    always_comb begin
        state_n   = state_q;
        wr        = '0;
        wr_v      = 1'b0;
        s_ready   = 1'b0;
        busy      = 1'b0;
        hdr_cap   = 1'b0;
        hdr_adv   = 1'b0;
        len_clr   = 1'b0;
        pay_fire  = 1'b0;
        pad_fire  = 1'b0;
        stop_load = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (!stop && s_valid) begin
                    if (q_ready) begin
                        hdr_cap = 1'b1;
                        state_n = ST_SOF;
                    end else begin
                        busy    = 1'b1;
                        state_n = ST_DROP;
                    end
                end
            end
            ST_SOF: begin
                wr_v     = 1'b1;
                wr.ctrl  = 1'b1;
                wr.sof   = 1'b1;
                wr.gap   = GAP_DEFAULT;
                len_clr  = 1'b1;
                state_n  = ST_HDR;
            end
            ST_HDR: begin
                wr_v     = 1'b1;
                wr.data  = hdr_word;
                hdr_adv  = 1'b1;
                if (hdr_last) state_n = ST_PAY;
            end
            ST_PAY: begin
                s_ready = 1'b1;
                if (s_valid) begin
                    wr_v     = 1'b1;
                    wr.data  = s_data;
                    pay_fire = 1'b1;
                    if (s_last) state_n = need_pad ? ST_PAD : ST_EOF;
                end
            end
            ST_PAD: begin
                wr_v     = 1'b1;
                pad_fire = 1'b1;
                if (!need_pad) state_n = ST_EOF;
            end
            ST_EOF: begin
                wr_v     = 1'b1;
                wr.ctrl  = 1'b1;
                wr.eof   = 1'b1;
                wr.gap   = GAP_DEFAULT;
                wr.vld   = end_valid_code(byte_cnt);
                state_n  = ST_TAIL;
            end
            ST_TAIL: begin
                wr_v      = 1'b1;
                stop_load = q_wmark;
                state_n   = ST_IDLE;
            end
            ST_DROP: begin
                s_ready = 1'b1;
                if (s_valid && s_last) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    assign wr_valid = wr_v;
    assign wr_ctrl  = wr.ctrl;
    assign wr_sof   = wr.sof;
    assign wr_eof   = wr.eof;
    assign wr_vld   = wr.vld;
    assign wr_gap   = wr.gap;
    assign wr_data  = wr.data;

    // Busy is a single pulse and no write follows it (R2)
    p_busy_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy && !wr_valid));

    // The start control write is followed by a data write (R4)
    p_hdr_after_sof_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_sof) |=> (wr_valid && !wr_ctrl));

    // The end control write carries gap 1 and no start flag (R7)
    p_eof_fields_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_eof) |-> (wr_ctrl && !wr_sof && wr_gap == GAP_DEFAULT));

    // One zero data word follows the end control write (R8)
    p_tail_word_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_eof) |=> (wr_valid && !wr_ctrl && wr_data == '0));

    // No stream accept and no write during backpressure (R10)
    p_stop_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        stop |-> (!s_ready && !wr_valid));

endmodule

// File: tb/inj_framer_tb.sv
module inj_framer_tb_top;
    localparam int HW = 9;
    localparam int SC = 6250;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic [31:0]   s_data = '0;
    logic [3:0]    s_keep = '0;
    logic          s_last = 1'b0;
    logic [32*HW-1:0] hdr_in = '0;
    logic          q_ready = 1'b1;
    logic          q_wmark = 1'b0;
    logic          busy, stop, wr_valid, wr_ctrl, wr_sof, wr_eof;
    logic [1:0]    wr_vld, wr_gap;
    logic [31:0]   wr_data;

    inj_framer #(.HDR_WORDS(HW), .STOP_CYCLES(SC)) dut_i (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_keep(s_keep), .s_last(s_last), .hdr_in(hdr_in),
        .q_ready(q_ready), .q_wmark(q_wmark), .busy(busy), .stop(stop),
        .wr_valid(wr_valid), .wr_ctrl(wr_ctrl), .wr_sof(wr_sof), .wr_eof(wr_eof),
        .wr_vld(wr_vld), .wr_gap(wr_gap), .wr_data(wr_data)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int nlog = 0, nbusy = 0, nstop = 0, nviol = 0;
    logic [38:0] logw  [0:511];
    logic [38:0] exp_w [0:511];
    logic [31:0] pay   [0:127];
    logic [32*HW-1:0] hdr_exp;

    function automatic logic [38:0] mk(input bit c, input bit so, input bit eo,
                                       input logic [1:0] v, input logic [1:0] g,
                                       input logic [31:0] d);
        return {c, so, eo, v, g, d};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid) begin
                if (nlog < 512) logw[nlog] = {wr_ctrl, wr_sof, wr_eof, wr_vld, wr_gap, wr_data};
                nlog++;
            end
            if (busy) nbusy++;
            if (stop) nstop++;
            if (stop && (s_ready || wr_valid)) nviol++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step_gap(input int maxgap);
        int g;
        g = (maxgap > 0) ? int'($urandom_range(maxgap, 0)) : 0;
        repeat (g) @(posedge clk);
        #1;
    endtask

    task automatic run_frame(input int len, input bit qrdy, input bit wm, input int maxgap);
        int nw, n, dw, rem;
        logic [3:0] klast;
        string req;
        nw  = (len + 3) / 4;
        rem = len % 4;
        klast = (rem == 0) ? 4'hF : 4'((1 << rem) - 1);
        for (int i = 0; i < nw; i++) pay[i] = $urandom;
        for (int i = 0; i < HW; i++) hdr_in[i*32 +: 32] = $urandom;
        hdr_exp = hdr_in;
        q_ready = qrdy;
        q_wmark = wm;
        nlog = 0; nbusy = 0; nstop = 0; nviol = 0;
        for (int w = 0; w < nw; w++) begin
            s_valid = 1'b1;
            s_data  = pay[w];
            s_keep  = (w == nw - 1) ? klast : 4'hF;
            s_last  = (w == nw - 1);
            @(negedge clk);
            while (!s_ready) @(negedge clk);
            @(posedge clk);
            #1;
            s_valid = 1'b0;
            s_last  = 1'b0;
            if (w == 0) for (int i = 0; i < HW; i++) hdr_in[i*32 +: 32] = $urandom;
            step_gap(maxgap);
        end
        q_ready = 1'b1;
        if (!qrdy) begin
            repeat (20) @(posedge clk);
            #1;
            chk(nbusy == 1, "R2", "busy pulses", 64'(nbusy), 64'd1);
            chk(nlog == 0, "R2", "writes for refused frame", 64'(nlog), 64'd0);
            return;
        end
        if (wm) begin
            @(negedge clk);
            while (!stop) @(negedge clk);
        end else begin
            repeat (25) @(posedge clk);
            #1;
        end
        n = 0;
        exp_w[n++] = mk(1, 1, 0, 2'd0, 2'd1, 32'd0);
        for (int i = 0; i < HW; i++) exp_w[n++] = mk(0, 0, 0, 2'd0, 2'd0, hdr_exp[i*32 +: 32]);
        for (int i = 0; i < nw; i++) exp_w[n++] = mk(0, 0, 0, 2'd0, 2'd0, pay[i]);
        dw = nw;
        while (dw < 15) begin exp_w[n++] = mk(0, 0, 0, 2'd0, 2'd0, 32'd0); dw++; end
        exp_w[n++] = mk(1, 0, 1, (len < 60) ? 2'd0 : 2'(len % 4), 2'd1, 32'd0);
        exp_w[n++] = mk(0, 0, 0, 2'd0, 2'd0, 32'd0);
        chk(nlog == n, "R8", "write count", 64'(nlog), 64'(n));
        for (int i = 0; i < n && i < nlog; i++) begin
            if (i == 0)                req = "R3";
            else if (i <= HW)          req = "R4";
            else if (i <= HW + nw)     req = "R5";
            else if (i < n - 2)        req = "R6";
            else if (i == n - 2)       req = "R7";
            else                       req = "R8";
            chk(logw[i] == exp_w[i], req, $sformatf("write %0d len %0d", i, len),
                64'(logw[i]), 64'(exp_w[i]));
        end
        if (wm) begin
            n = nlog;
            s_valid = 1'b1; s_data = 32'hA5A5_0001; s_keep = 4'hF; s_last = 1'b1;
            while (stop) @(negedge clk);
            s_valid = 1'b0; s_last = 1'b0;
            q_wmark = 1'b0;
            chk(nstop == SC, "R9", "stop length", 64'(nstop), 64'(SC));
            chk(nviol == 0, "R10", "accept or write during stop", 64'(nviol), 64'd0);
            chk(nlog == n, "R10", "writes during stop", 64'(nlog), 64'(n));
            @(posedge clk);
            #1;
        end
        q_wmark = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk(!wr_valid, "R1", "wr_valid after reset", 64'(wr_valid), 64'd0);
        chk(!s_ready, "R1", "s_ready after reset", 64'(s_ready), 64'd0);
        chk(!busy && !stop, "R1", "busy/stop after reset", 64'({busy, stop}), 64'd0);
        @(posedge clk);
        #1;
        // directed lengths around the minimum and all residues
        run_frame(1, 1, 0, 0);
        run_frame(4, 1, 0, 2);
        run_frame(57, 1, 0, 0);
        run_frame(59, 1, 0, 1);
        run_frame(60, 1, 0, 0);
        run_frame(61, 1, 0, 2);
        run_frame(62, 1, 0, 0);
        run_frame(63, 1, 0, 0);
        run_frame(64, 1, 0, 3);
        run_frame(200, 1, 0, 1);
        // refused frames (R2)
        run_frame(30, 0, 0, 1);
        run_frame(90, 0, 0, 0);
        // watermark backpressure (R9, R10)
        run_frame(70, 1, 1, 0);
        run_frame(10, 1, 0, 0);
        // random mix
        for (int k = 0; k < 24; k++) begin
            run_frame(int'($urandom_range(200, 1)), ($urandom_range(7, 0) != 0), 1'b0,
                      int'($urandom_range(2, 0)));
        end
        run_frame(45, 1, 1, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule